// File: doc/BRIEF.md
# Locally Triplicated Register Bank

This block is a register bank built to survive single-event upsets. Every stored bit is held in three flip-flops, and a two-of-three majority voter resolves the three copies into one bit before it leaves the block. Only the storage is triplicated. The clock, the synchronous reset, the load enable and the data input are single, and all three copies take them in common. One upset copy is therefore masked at the output straight away, and no correction cycle is needed.

A per-bit flag shows where the copies of a bit do not all agree, so a test or a monitor can see a latent upset that the voter is hiding. For test, an injection port inverts chosen copies at a clock edge. A corrupted copy stays wrong until the next load or reset, because every copy reloads from the shared input.

Top module: `ltmr_regbank`

## Requirements
- R1: When `rst` is high at a rising clock edge, all three copies of every bit take `RESET_VAL`. After that edge `q` equals `RESET_VAL` and `mismatch` is zero.
- R2: When `load` is high and `rst` is low at an edge, and no upset is injected, all three copies take `d_in`. After that edge `q` equals `d_in` and `mismatch` is zero.
- R3: When `load` and `rst` are low at an edge and no upset is injected, all copies keep their values, so `q` and `mismatch` do not change.
- R4: `upset` bit `k*WIDTH+i` inverts bit `i` of copy `k` (k = 0, 1, 2) at an edge where `rst` is low. If only one copy of a bit is wrong, `q` keeps the value the other two copies hold.
- R5: `mismatch[i]` is high exactly when the three copies of bit `i` are not all equal. Once an upset makes it high, it stays high on edges without a load until a load or a reset.
- R6: `q[i]` is the majority of the three copies, `(a&b)|(b&c)|(c&a)`. If two copies of a bit are upset, `q[i]` follows them. If all three are upset, `q[i]` inverts and `mismatch[i]` stays low.
- R7: A corrupted copy recovers on the next edge with `load` high, and `mismatch` then returns to zero.
- R8: Reset has priority over both `load` and `upset`. An injection made while `rst` is high has no effect.
- R9: When an upset and a load happen at the same edge, the copy takes the inverted `d_in`. `q` still shows `d_in` and the affected `mismatch` bit goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all three copies |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Load enable; when high, all copies take `d_in` at the edge |
| d_in | input | WIDTH | Data input, fanned out to all three copies |
| upset | input | 3*WIDTH | Fault injection; bit `k*WIDTH+i` inverts copy `k`, bit `i` |
| q | output | WIDTH | Majority-voted stored value |
| mismatch | output | WIDTH | High per bit where the three copies disagree |

## Verification
The bench builds the bank with `WIDTH` = 12 and a `RESET_VAL` of 12'hA5C. That reset value mixes ones and zeros, so a reset that did not happen, or a reset that only went to zero, shows up on individual bits. The 12-bit width places copy 1 and copy 2 in the middle and the top of the 36-bit `upset` vector, which exercises the slicing of the injection port for every copy and not only the lowest one. Single, double and triple upsets on the same bit, and an upset at the same edge as a load, give each voter outcome and the persistence and clearing of the flag.

// File: rtl/ltmr_regbank.sv
module ltmr_regbank #(
  parameter int WIDTH = 8,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic [WIDTH-1:0]     d_in,
  input  logic [3*WIDTH-1:0]   upset,
  output logic [WIDTH-1:0]     q,
  output logic [WIDTH-1:0]     mismatch
);
  localparam int COPIES = 3;

  for (genvar k = 0; k < COPIES; k++) begin : g_copy
    logic [WIDTH-1:0] bits;
    wire  [WIDTH-1:0] flip = upset[k*WIDTH +: WIDTH];
    always_ff @(posedge clk) begin
      if (rst) bits <= RESET_VAL;
      else     bits <= (load ? d_in : bits) ^ flip;
    end
  end

  wire [WIDTH-1:0] a = g_copy[0].bits;
  wire [WIDTH-1:0] b = g_copy[1].bits;
  wire [WIDTH-1:0] c = g_copy[2].bits;

  assign q        = (a & b) | (b & c) | (c & a);
  assign mismatch = (a ^ b) | (b ^ c);

  wire [WIDTH-1:0] overlap = (g_copy[0].flip & g_copy[1].flip) |
                             (g_copy[1].flip & g_copy[2].flip) |
                             (g_copy[2].flip & g_copy[0].flip);

  p_reset_value_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (q == RESET_VAL && mismatch == '0));

  p_load_takes_input_r2: assert property (@(posedge clk) disable iff (rst)
    (load && upset == '0) |=> (q == $past(d_in) && mismatch == '0));

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!load && upset == '0) |=> ($stable(q) && $stable(mismatch)));

  p_single_upset_masked_r4: assert property (@(posedge clk) disable iff (rst)
    (!load && mismatch == '0 && overlap == '0) |=> $stable(q));

  p_flag_sticks_r5: assert property (@(posedge clk) disable iff (rst)
    (!load && upset == '0 && mismatch != '0) |=> (mismatch == $past(mismatch)));

endmodule

// File: tb/ltmr_regbank_bench.sv
module ltmr_regbank_bench;
  localparam int W = 12;
  localparam logic [W-1:0] RV = 12'hA5C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load = 1'b0;
  logic [W-1:0] d_in = '0;
  logic [3*W-1:0] upset = '0;
  logic [W-1:0] q, mismatch;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  ltmr_regbank #(.WIDTH(W), .RESET_VAL(RV)) u_ltmr_regbank (
    .clk(clk), .rst(rst), .load(load), .d_in(d_in), .upset(upset),
    .q(q), .mismatch(mismatch));

  task automatic check(string req, logic [W-1:0] qe, logic [W-1:0] me);
    checks++;
    if (q !== qe || mismatch !== me) begin
      fails++;
      $display("FAIL %s: q=%h mismatch=%h expected q=%h mismatch=%h",
               req, q, mismatch, qe, me);
    end
  endtask

  task automatic step(logic r, logic ld, logic [W-1:0] d, logic [3*W-1:0] up);
    @(negedge clk);
    rst = r; load = ld; d_in = d; upset = up;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [3*W-1:0] hit(int k, int i);
    logic [3*W-1:0] m = '0;
    m[k*W+i] = 1'b1;
    return m;
  endfunction

  task automatic t_reset();
    step(1, 1, 12'hFFF, '1);
    step(1, 1, 12'hFFF, '1);
    check("R8 reset beats load and upset", RV, '0);
    step(0, 0, '0, '0);
    check("R1 reset value held after release", RV, '0);
  endtask

  task automatic t_load();
    logic [W-1:0] pats [4] = '{12'h000, 12'hFFF, 12'h5A3, 12'h3C6};
    foreach (pats[n]) begin
      step(0, 1, pats[n], '0);
      check("R2 load", pats[n], '0);
    end
    step(0, 0, 12'h123, '0);
    check("R3 hold with load low", 12'h3C6, '0);
  endtask

  task automatic t_single();
    for (int k = 0; k < 3; k++) begin
      int i = k * 4 + 1;
      step(0, 1, 12'h0F0, '0);
      step(0, 0, '0, hit(k, i));
      check("R4 single copy upset masked", 12'h0F0, W'(1) << i);
      step(0, 0, 12'hABC, '0);
      check("R5 flag persists without load", 12'h0F0, W'(1) << i);
      step(0, 1, 12'h0F0, '0);
      check("R7 reload recovers copy", 12'h0F0, '0);
    end
  endtask

  task automatic t_double();
    step(0, 1, 12'h0F0, '0);
    step(0, 0, '0, hit(0, 4) | hit(1, 4));
    check("R6 two copies outvote", 12'h0E0, 12'h010);
    step(0, 1, 12'h0F0, '0);
    check("R7 reload after double upset", 12'h0F0, '0);
    step(0, 0, '0, hit(0, 11) | hit(1, 11) | hit(2, 11));
    check("R6 three copies flip output", 12'h8F0, '0);
  endtask

  task automatic t_load_upset();
    step(0, 1, 12'h321, hit(2, 0));
    check("R9 upset at load edge", 12'h321, 12'h001);
    step(1, 0, '0, hit(1, 3));
    step(0, 0, '0, '0);
    check("R8 reset clears corruption", RV, '0);
  endtask

  initial begin
    t_reset();
    t_load();
    t_single();
    t_double();
    t_load_upset();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule